// File: doc/BRIEF.md
# Match Timer with Event-Count and Square-Wave Divider Modes

This block is an 8-bit up-counter that is compared with a programmable match value. The active mode decides what makes the counter advance. In timer mode it advances on each cycle where the internal count enable is high. In event mode it advances on each qualified falling edge of an asynchronous external pin. In divider mode it advances on the count enable, and every match inverts a toggle flip-flop. The output pin carries the inverse of that flip-flop, so the result is a square wave with 50% duty.

On every match the counter returns to zero and a one-cycle interrupt pulse is issued. Software configures the block through two plain write strobes. The first loads the run bit, the mode and the toggle flip-flop preset. The second loads the match value. Neither write has any handshake. A write takes effect at the clock edge where its strobe is high, and it is never held back. The block has no data stream, so there is no valid/ready interface and no back-pressure.

Top module: `evtimer_top`

## Requirements
- R1: In a cycle where the block is running and a counting tick occurs with count equal to the compare value, the count returns to 0 and `irq` is high for exactly the next cycle. With a steady tick, consecutive pulses are therefore compare+1 ticks apart.
- R2: Mode code 00 (timer) advances the count once per cycle in which `cnt_en` is high.
- R3: Mode code 01 (event) advances the count once per qualified falling edge of `ev_pin` and ignores `cnt_en`. After a match clear, counting continues with the next qualified falling edge.
- R4: `ev_pin` passes through a two-flop synchroniser. A falling edge qualifies only if a high level held for at least two consecutive samples is followed by a low level held for at least two consecutive samples. A low or high level that lasts a single cycle is ignored.
- R5: Mode code 10 (divider) advances on `cnt_en`, and every match inverts the toggle flip-flop. In the other modes the flip-flop keeps its value. `div_out` always equals the inverse of the flip-flop.
- R6: A `cfg_wr` strobe loads the flip-flop from `cfg_tff`, and this takes priority over a toggle in the same cycle. Reset clears the flip-flop, so `div_out` is 1.
- R7: In event mode, a `match_wr` strobe replaces the compare value at once. A count already above the new value wraps past 255 to 0 before it can match.
- R8: In timer and divider modes, `match_wr` writes only a shadow copy. The shadow loads into the compare value on each match clear and on every cycle in which the counter is stopped.
- R9: While the run bit is 0, or while the mode code is the reserved value 11, the count is held at 0 and no `irq` is issued.
- R10: After reset the block is stopped in timer mode with compare and shadow values of 255, `irq` low and `div_out` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling and system clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cnt_en | input | 1 | Internal count enable for timer and divider modes |
| ev_pin | input | 1 | Asynchronous external event input |
| cfg_wr | input | 1 | Strobe that loads run bit, mode and flip-flop preset |
| cfg_run | input | 1 | Run (1) or stop (0) |
| cfg_mode | input | 2 | 00 timer, 01 event, 10 divider, 11 reserved |
| cfg_tff | input | 1 | Preset value for the toggle flip-flop |
| match_wr | input | 1 | Strobe that loads a match value |
| match_val | input | 8 | Match value |
| irq | output | 1 | One-cycle pulse per match |
| div_out | output | 1 | Inverse of the toggle flip-flop |

## Verification
The hardest part to reach from the ports is the edge qualifier in event mode. The stimulus therefore shapes `ev_pin` directly. It drives single-cycle low glitches inside long highs, which must never count. It then drives clean three-cycle lows and highs with a compare value of 0, so that every qualified edge shows up as its own `irq` pulse. It also lowers the compare value in event mode while the count already sits above it, which forces the wrap through 255. A behavioural model in the bench tracks `irq` and `div_out` on every cycle.

// File: rtl/evt_pkg.sv
package evt_pkg;
  typedef enum logic [1:0] {
    MODE_TIMER = 2'b00,
    MODE_EVENT = 2'b01,
    MODE_DIV   = 2'b10,
    MODE_RSVD  = 2'b11
  } mode_e;
endpackage

// File: rtl/evt_edge_filter.sv
// Synchronises the external pin, then qualifies falling edges on stable levels.
module evt_edge_filter #(
  parameter int SYNC_STAGES = 2,
  parameter int STABLE_LEN  = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_async,
  output logic fall_o
);
  localparam int DW = $clog2(STABLE_LEN + 1);
  localparam logic [DW-1:0] LAST = DW'(STABLE_LEN - 1);

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   sample;
  logic                   level_q;
  logic [DW-1:0]          diff_cnt;
  logic                   differ;

  generate
    if (SYNC_STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) sync_q <= '0;
        else        sync_q <= pin_async;
    end else begin : g_chain
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) sync_q <= '0;
        else        sync_q <= {sync_q[SYNC_STAGES-2:0], pin_async};
    end
  endgenerate

  assign sample = sync_q[SYNC_STAGES-1];
  assign differ = (sample != level_q);
  assign fall_o = level_q & ~sample & (diff_cnt == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      level_q  <= 1'b0;
      diff_cnt <= '0;
    end else if (differ) begin
      if (diff_cnt == LAST) begin
        level_q  <= sample;
        diff_cnt <= '0;
      end else begin
        diff_cnt <= diff_cnt + 1'b1;
      end
    end else begin
      diff_cnt <= '0;
    end
  end
endmodule

// File: rtl/evt_match_counter.sv
// Up-counter with compare register and optional shadow.
module evt_match_counter #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         run_i,
  input  logic         evt_mode_i,
  input  logic         tick_i,
  input  logic         wr_i,
  input  logic [W-1:0] wr_val_i,
  output logic         match_o,
  output logic [W-1:0] count_o,
  output logic [W-1:0] cmp_o
);
  logic [W-1:0] cnt_q, cmp_q, shadow_q;
  logic         hit;

  assign hit     = (cnt_q == cmp_q);
  assign match_o = run_i & tick_i & hit;
  assign count_o = cnt_q;
  assign cmp_o   = cmp_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q    <= '0;
      cmp_q    <= '1;
      shadow_q <= '1;
    end else begin
      if (!run_i) begin
        cnt_q <= '0;
        cmp_q <= shadow_q;
      end else if (tick_i) begin
        if (hit) begin
          cnt_q <= '0;
          if (!evt_mode_i) cmp_q <= shadow_q;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
      if (wr_i) begin
        shadow_q <= wr_val_i;
        if (evt_mode_i) cmp_q <= wr_val_i;
      end
    end
  end
endmodule

// File: rtl/evt_div_out.sv
// Presettable toggle flip-flop; the pin carries its inverse.
module evt_div_out (
  input  logic clk,
  input  logic rst_n,
  input  logic toggle_i,
  input  logic preset_wr_i,
  input  logic preset_val_i,
  output logic pin_o
);
  logic ff_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           ff_q <= 1'b0;
    else if (preset_wr_i) ff_q <= preset_val_i;
    else if (toggle_i)    ff_q <= ~ff_q;
  end
  assign pin_o = ~ff_q;
endmodule

// File: rtl/evtimer_top.sv
module evtimer_top #(
  parameter int W           = 8,
  parameter int SYNC_STAGES = 2,
  parameter int STABLE_LEN  = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cnt_en,
  input  logic         ev_pin,
  input  logic         cfg_wr,
  input  logic         cfg_run,
  input  logic [1:0]   cfg_mode,
  input  logic         cfg_tff,
  input  logic         match_wr,
  input  logic [W-1:0] match_val,
  output logic         irq,
  output logic         div_out
);
  import evt_pkg::*;

  mode_e        mode_q;
  logic         run_q;
  logic         fall;
  logic         tick;
  logic         active;
  logic         evt_mode;
  logic         match;
  logic         irq_q;
  logic [W-1:0] count;
  logic [W-1:0] cmp;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= MODE_TIMER;
      run_q  <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      irq_q <= match;
      if (cfg_wr) begin
        mode_q <= mode_e'(cfg_mode);
        run_q  <= cfg_run;
      end
    end
  end

  assign evt_mode = (mode_q == MODE_EVENT);
  assign active   = run_q & (mode_q != MODE_RSVD);
  assign tick     = evt_mode ? fall : cnt_en;
  assign irq      = irq_q;

  evt_edge_filter #(.SYNC_STAGES(SYNC_STAGES), .STABLE_LEN(STABLE_LEN)) u_filt (
    .clk(clk), .rst_n(rst_n), .pin_async(ev_pin), .fall_o(fall));

  evt_match_counter #(.W(W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .run_i(active), .evt_mode_i(evt_mode),
    .tick_i(tick), .wr_i(match_wr), .wr_val_i(match_val),
    .match_o(match), .count_o(count), .cmp_o(cmp));

  evt_div_out u_div (
    .clk(clk), .rst_n(rst_n), .toggle_i(match & (mode_q == MODE_DIV)),
    .preset_wr_i(cfg_wr), .preset_val_i(cfg_tff), .pin_o(div_out));
endmodule

// File: rtl/evtimer_checker.sv
module evtimer_checker #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         irq,
  input logic         div_out,
  input logic         cfg_wr,
  input logic         match_wr,
  input logic [W-1:0] match_val,
  input logic [1:0]   mode_q,
  input logic         active,
  input logic         fall,
  input logic [W-1:0] count,
  input logic [W-1:0] cmp
);
  AST_IRQ_COUNT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (count == '0)); // R1
  AST_FALL_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    fall |=> !fall); // R4
  AST_DIV_TOGGLES: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && $past(mode_q) == 2'b10 && !$past(cfg_wr)) |-> (div_out != $past(div_out))); // R5
  AST_DIV_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(mode_q) != 2'b10 && !$past(cfg_wr)) |-> $stable(div_out)); // R5
  AST_EVENT_WRITE_NOW: assert property (@(posedge clk) disable iff (!rst_n)
    (match_wr && mode_q == 2'b01) |=> (cmp == $past(match_val))); // R7
  AST_STOPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !active |=> (count == '0)); // R9
endmodule

bind evtimer_top evtimer_checker #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .irq(irq), .div_out(div_out), .cfg_wr(cfg_wr),
  .match_wr(match_wr), .match_val(match_val), .mode_q(mode_q), .active(active),
  .fall(fall), .count(count), .cmp(cmp));

// File: tb/evtimer_top_test.sv
module evtimer_top_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cnt_en = 1'b0, ev_pin = 1'b1;
  logic cfg_wr = 1'b0, cfg_run = 1'b0, cfg_tff = 1'b0, match_wr = 1'b0;
  logic [1:0] cfg_mode = 2'b00;
  logic [7:0] match_val = 8'd0;
  logic irq, div_out;

  int checks = 0, fails = 0, cycles = 0, irq_seen = 0;
  string tag = "R10";
  bit done = 0;

  evtimer_top uut (.clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .ev_pin(ev_pin),
    .cfg_wr(cfg_wr), .cfg_run(cfg_run), .cfg_mode(cfg_mode), .cfg_tff(cfg_tff),
    .match_wr(match_wr), .match_val(match_val), .irq(irq), .div_out(div_out));

  always #2.5 clk = ~clk;

  // behavioural reference
  int m_s1, m_s2, m_q, m_dc, m_cnt, m_cmp, m_sh, m_run, m_mode, m_ff, m_irq;
  always @(posedge clk) begin
    if (!rst_n) begin
      m_s1 = 0; m_s2 = 0; m_q = 0; m_dc = 0; m_cnt = 0; m_cmp = 255; m_sh = 255;
      m_run = 0; m_mode = 0; m_ff = 0; m_irq = 0;
    end else begin
      int fall, act, tk, tog;
      fall = (m_q == 1 && m_s2 == 0 && m_dc == 1);
      if (m_s2 != m_q) begin
        if (m_dc == 1) begin m_q = m_s2; m_dc = 0; end else m_dc = m_dc + 1;
      end else m_dc = 0;
      m_s2 = m_s1; m_s1 = ev_pin;
      act = (m_run == 1 && m_mode != 3);
      tk = (m_mode == 1) ? fall : int'(cnt_en);
      m_irq = 0; tog = 0;
      if (!act) begin m_cnt = 0; m_cmp = m_sh; end
      else if (tk != 0) begin
        if (m_cnt == m_cmp) begin
          m_cnt = 0; m_irq = 1;
          if (m_mode != 1) m_cmp = m_sh;
          if (m_mode == 2) tog = 1;
        end else m_cnt = (m_cnt + 1) % 256;
      end
      if (match_wr) begin m_sh = match_val; if (m_mode == 1) m_cmp = match_val; end
      if (cfg_wr) m_ff = cfg_tff; else if (tog != 0) m_ff = 1 - m_ff;
      if (cfg_wr) begin m_run = cfg_run; m_mode = cfg_mode; end
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at cycle %0d", req, act, exp, cycles);
    end
  endtask

  always @(negedge clk) begin
    cycles++;
    if (rst_n && !done) begin
      chk(tag, irq, m_irq);
      chk(tag, div_out, 1 - m_ff);
      if (irq) irq_seen++;
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask
  task automatic wcfg(input logic run, input logic [1:0] mode, input logic tff);
    cfg_run = run; cfg_mode = mode; cfg_tff = tff; cfg_wr = 1'b1;
    cyc(1); cfg_wr = 1'b0;
  endtask
  task automatic wmatch(input int v);
    match_val = v[7:0]; match_wr = 1'b1;
    cyc(1); match_wr = 1'b0;
  endtask
  task automatic ev_pulse(input int lo, input int hi);
    ev_pin = 1'b0; cyc(lo); ev_pin = 1'b1; cyc(hi);
  endtask

  initial begin
    int base;
    cyc(3);
    chk("R10", irq, 0);
    chk("R10", div_out, 1);
    rst_n = 1'b1;
    cyc(2);
    chk("R10", div_out, 1);

    // R8: shadow loads while stopped; R2 timer counting
    tag = "R8"; wmatch(3); cyc(2);
    tag = "R2"; wcfg(1, 2'b00, 1'b0);
    cnt_en = 1'b1; cyc(8);
    base = irq_seen; cyc(20);
    chk("R1", irq_seen - base, 5);
    for (int i = 0; i < 30; i++) begin cnt_en = i[0] | i[2]; cyc(1); end
    // R8: write while running waits for the next clear
    tag = "R8"; cnt_en = 1'b1; wmatch(6); cyc(30);

    // R5 divider, R6 preset
    tag = "R5"; wmatch(2); wcfg(1, 2'b10, 1'b0);
    for (int i = 0; i < 40; i++) begin cnt_en = (i % 3 != 0); cyc(1); end
    tag = "R6"; wcfg(1, 2'b10, 1'b1); cnt_en = 1'b1; cyc(15);
    wcfg(1, 2'b10, 1'b0); cyc(15);

    // R9 stopped and reserved mode
    tag = "R9"; wcfg(0, 2'b00, 1'b0); cyc(4);
    base = irq_seen; cyc(20);
    chk("R9", irq_seen - base, 0);
    wcfg(1, 2'b11, 1'b0); cyc(2);
    base = irq_seen; cyc(20);
    chk("R9", irq_seen - base, 0);

    // R3/R4 event mode, compare 0 so each counted edge raises irq
    tag = "R4"; cnt_en = 1'b1; ev_pin = 1'b1;
    wcfg(1, 2'b01, 1'b0); wmatch(0); cyc(6);
    base = irq_seen;
    for (int i = 0; i < 6; i++) ev_pulse(1, 4);
    cyc(4);
    chk("R4", irq_seen - base, 0);
    tag = "R3"; base = irq_seen;
    for (int i = 0; i < 7; i++) ev_pulse(3, 3);
    cyc(4);
    chk("R3", irq_seen - base, 7);
    wmatch(2);
    for (int i = 0; i < 9; i++) ev_pulse(2, 2);
    cyc(4);

    // R7 immediate write: count above new value must wrap
    tag = "R7"; wmatch(9);
    for (int i = 0; i < 5; i++) ev_pulse(2, 2);
    wmatch(1); base = irq_seen;
    for (int i = 0; i < 6; i++) ev_pulse(2, 2);
    cyc(4);
    chk("R7", irq_seen - base, 0);
    ev_pin = 1'b1; cnt_en = 1'b0;
    cyc(4);

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(5 * 100000);
    fails++; checks++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule